// File: doc/BRIEF.md
# JTAG Test Access Port Controller with Instruction Register

This block is the serial test port of a chip. A test clock and a mode-select line steer a sixteen-state controller. That controller decides whether the serial input is loaded into a 4-bit instruction register or into the data register that the current instruction selects. The serial output reports the shifted-out bits. It changes on the falling test-clock edge and is enabled only while bits are being shifted.

The held instruction is decoded into three mutually exclusive path selects: the external boundary chain, a one-bit bypass stage and a debug-access path. Opcode 0x1 selects the boundary chain, and the boundary outputs are enabled as soon as that opcode is held. Per-state strobes (capture, shift, update) and a serial-in copy go out to the data registers outside the block. Their serial outputs come back on two inputs. The current controller state is brought out as a fixed 4-bit code.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: The state advances only on the rising test-clock edge and depends only on mode_sel, following the sixteen-state test-port graph. The state codes are: Reset=F, Idle=C, SelDR=7, CapDR=6, ShDR=2, Ex1DR=1, PauseDR=3, Ex2DR=0, UpdDR=5, SelIR=4, CapIR=E, ShIR=A, Ex1IR=9, PauseIR=B, Ex2IR=8, UpdIR=D.
- R2: A low por_n forces the Reset state (code F) asynchronously. Five consecutive rising edges with mode_sel high reach Reset from any state.
- R3: The instruction register is 4 bits wide. While in ShIR, each rising edge shifts ser_in into bit 3 and moves the other bits toward bit 0, so the register shifts LSB first. The last bit is taken on the edge that leaves ShIR with mode_sel high.
- R4: The rising edge leaving CapIR loads the shift stage with 0x1. Its bits appear on ser_out in the order 1,0,0,0 during ShIR.
- R5: ir_value takes the shifted pattern only on the rising edge leaving UpdIR. Passing through Ex1IR, PauseIR and Ex2IR leaves ir_value unchanged.
- R6: ir_value 0x1 selects the boundary path and 0x7 selects the debug path. Every other value, including 0xF, selects bypass. Exactly one select is high at any time.
- R7: The power-on reset, and every rising edge taken in Reset, set ir_value to 0xF (bypass).
- R8: With bypass selected, the edge leaving CapDR clears the bypass bit. Shifted data then appears on ser_out one bit late, starting with that 0.
- R9: ser_out and ser_oe change only on falling edges. ser_oe is high exactly while the state is ShIR or ShDR. ser_out is 0 whenever ser_oe is low.
- R10: dr_capture, dr_shift and dr_update are high exactly in CapDR, ShDR and UpdDR. dr_si follows ser_in. In ShDR, ser_out returns bnd_so or dbg_so, whichever path is selected.
- R11: bnd_drive is high whenever ir_value is 0x1, starting on the same edge that loads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_clk | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| mode_sel | input | 1 | Mode select, steers the state machine |
| ser_in | input | 1 | Serial data input |
| ser_out | output | 1 | Serial data output, falling-edge timed |
| ser_oe | output | 1 | Output enable for ser_out |
| state_code | output | 4 | Current controller state code |
| ir_value | output | 4 | Held instruction |
| sel_boundary | output | 1 | Boundary chain selected |
| sel_bypass | output | 1 | Bypass bit selected |
| sel_debug | output | 1 | Debug-access path selected |
| bnd_drive | output | 1 | Enable for the boundary cells to drive the pins |
| dr_capture | output | 1 | Data register capture strobe |
| dr_shift | output | 1 | Data register shift strobe |
| dr_update | output | 1 | Data register update strobe |
| dr_si | output | 1 | Serial input to the selected data register |
| bnd_so | input | 1 | Serial output of the boundary chain |
| dbg_so | input | 1 | Serial output of the debug-access path |

## Verification
The final shift of a register and the exit from the shift state happen on the same rising edge. A misplaced shift would either drop the last bit or take one bit too many. The bench shifts the instruction and data with mode_sel raised together with the last bit. It then judges the captured boundary chain contents, the new ir_value, and the one-bit delay of the bypass output against its own bit-order model. A second collision is that an instruction load also turns on the boundary drive. This is checked by reading bnd_drive right after the update edge, and by confirming that ir_value holds through a Pause-IR detour.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET   = 4'hF,
    ST_IDLE    = 4'hC,
    ST_SEL_DR  = 4'h7,
    ST_CAP_DR  = 4'h6,
    ST_SH_DR   = 4'h2,
    ST_EX1_DR  = 4'h1,
    ST_PA_DR   = 4'h3,
    ST_EX2_DR  = 4'h0,
    ST_UPD_DR  = 4'h5,
    ST_SEL_IR  = 4'h4,
    ST_CAP_IR  = 4'hE,
    ST_SH_IR   = 4'hA,
    ST_EX1_IR  = 4'h9,
    ST_PA_IR   = 4'hB,
    ST_EX2_IR  = 4'h8,
    ST_UPD_IR  = 4'hD
  } tap_state_e;

  function automatic tap_state_e tap_next(tap_state_e cur, logic m);
    tap_state_e nxt;
    case (cur)
      ST_RESET:  nxt = m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = m ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  nxt = m ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: nxt = m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = m ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  nxt = m ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: nxt = m ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = m ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
    return nxt;
  endfunction

  typedef enum logic [1:0] {
    PATH_BYPASS   = 2'd0,
    PATH_BOUNDARY = 2'd1,
    PATH_DEBUG    = 2'd2
  } dr_path_e;

  function automatic dr_path_e op_decode(logic [3:0] op, logic [3:0] op_bnd, logic [3:0] op_dbg);
    if (op == op_bnd)      return PATH_BOUNDARY;
    else if (op == op_dbg) return PATH_DEBUG;
    else                   return PATH_BYPASS;
  endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode,
  output logic [3:0] code,
  output logic       in_reset,
  output logic       in_cap_ir,
  output logic       in_sh_ir,
  output logic       in_upd_ir,
  output logic       in_cap_dr,
  output logic       in_sh_dr,
  output logic       in_upd_dr
);
  tap_state_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RESET;
    else        st_q <= tap_next(st_q, mode);
  end

  assign code      = st_q;
  assign in_reset  = (st_q == ST_RESET);
  assign in_cap_ir = (st_q == ST_CAP_IR);
  assign in_sh_ir  = (st_q == ST_SH_IR);
  assign in_upd_ir = (st_q == ST_UPD_IR);
  assign in_cap_dr = (st_q == ST_CAP_DR);
  assign in_sh_dr  = (st_q == ST_SH_DR);
  assign in_upd_dr = (st_q == ST_UPD_DR);
endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir #(
  parameter int          IR_W     = 4,
  parameter logic [IR_W-1:0] CAP_VAL  = 'h1,
  parameter logic [IR_W-1:0] RST_VAL  = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_reset,
  input  logic            in_cap,
  input  logic            in_sh,
  input  logic            in_upd,
  input  logic            sin,
  output logic [IR_W-1:0] shift_q,
  output logic [IR_W-1:0] hold_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      shift_q <= CAP_VAL;
    else if (in_cap) shift_q <= CAP_VAL;
    else if (in_sh)  shift_q <= {sin, shift_q[IR_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= RST_VAL;
    else if (in_reset) hold_q <= RST_VAL;
    else if (in_upd)   hold_q <= shift_q;
  end
endmodule

// File: rtl/jtag_tap_drpath.sv
module jtag_tap_drpath
  import jtag_tap_pkg::*;
#(
  parameter int              IR_W   = 4,
  parameter logic [IR_W-1:0] OP_BND = 'h1,
  parameter logic [IR_W-1:0] OP_DBG = 'h7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IR_W-1:0] ir,
  input  logic            in_cap_dr,
  input  logic            in_sh_dr,
  input  logic            sin,
  input  logic            bnd_so,
  input  logic            dbg_so,
  output logic            sel_bnd,
  output logic            sel_byp,
  output logic            sel_dbg,
  output logic            byp_q,
  output logic            dr_bit
);
  dr_path_e path;

  assign path    = op_decode(4'(ir), 4'(OP_BND), 4'(OP_DBG));
  assign sel_bnd = (path == PATH_BOUNDARY);
  assign sel_dbg = (path == PATH_DEBUG);
  assign sel_byp = (path == PATH_BYPASS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     byp_q <= 1'b0;
    else if (sel_byp && in_cap_dr)  byp_q <= 1'b0;
    else if (sel_byp && in_sh_dr)   byp_q <= sin;
  end

  always_comb begin
    case (path)
      PATH_BOUNDARY: dr_bit = bnd_so;
      PATH_DEBUG:    dr_bit = dbg_so;
      default:       dr_bit = byp_q;
    endcase
  end
endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl #(
  parameter int IR_W   = 4,
  parameter int OP_BND = 1,
  parameter int OP_DBG = 7,
  parameter int IR_CAP = 1
) (
  input  logic            test_clk,
  input  logic            por_n,
  input  logic            mode_sel,
  input  logic            ser_in,
  output logic            ser_out,
  output logic            ser_oe,
  output logic [3:0]      state_code,
  output logic [IR_W-1:0] ir_value,
  output logic            sel_boundary,
  output logic            sel_bypass,
  output logic            sel_debug,
  output logic            bnd_drive,
  output logic            dr_capture,
  output logic            dr_shift,
  output logic            dr_update,
  output logic            dr_si,
  input  logic            bnd_so,
  input  logic            dbg_so
);
  localparam logic [IR_W-1:0] CAP_V = IR_W'(IR_CAP);
  localparam logic [IR_W-1:0] BND_V = IR_W'(OP_BND);
  localparam logic [IR_W-1:0] DBG_V = IR_W'(OP_DBG);

  logic            in_reset, in_cap_ir, in_sh_ir, in_upd_ir;
  logic            in_cap_dr, in_sh_dr, in_upd_dr;
  logic [IR_W-1:0] ir_shift;
  logic            byp_q, dr_bit;
  logic            so_next, oe_next;

  jtag_tap_fsm u_fsm (
    .clk(test_clk), .rst_n(por_n), .mode(mode_sel), .code(state_code),
    .in_reset(in_reset), .in_cap_ir(in_cap_ir), .in_sh_ir(in_sh_ir),
    .in_upd_ir(in_upd_ir), .in_cap_dr(in_cap_dr), .in_sh_dr(in_sh_dr),
    .in_upd_dr(in_upd_dr)
  );

  jtag_tap_ir #(.IR_W(IR_W), .CAP_VAL(CAP_V), .RST_VAL('1)) u_ir (
    .clk(test_clk), .rst_n(por_n), .in_reset(in_reset), .in_cap(in_cap_ir),
    .in_sh(in_sh_ir), .in_upd(in_upd_ir), .sin(ser_in),
    .shift_q(ir_shift), .hold_q(ir_value)
  );

  jtag_tap_drpath #(.IR_W(IR_W), .OP_BND(BND_V), .OP_DBG(DBG_V)) u_dr (
    .clk(test_clk), .rst_n(por_n), .ir(ir_value), .in_cap_dr(in_cap_dr),
    .in_sh_dr(in_sh_dr), .sin(ser_in), .bnd_so(bnd_so), .dbg_so(dbg_so),
    .sel_bnd(sel_boundary), .sel_byp(sel_bypass), .sel_dbg(sel_debug),
    .byp_q(byp_q), .dr_bit(dr_bit)
  );

  assign oe_next = in_sh_ir | in_sh_dr;
  assign so_next = in_sh_ir ? ir_shift[0] : (in_sh_dr ? dr_bit : 1'b0);

  always_ff @(negedge test_clk or negedge por_n) begin
    if (!por_n) begin
      ser_out <= 1'b0;
      ser_oe  <= 1'b0;
    end else begin
      ser_out <= so_next;
      ser_oe  <= oe_next;
    end
  end

  assign bnd_drive  = sel_boundary;
  assign dr_capture = in_cap_dr;
  assign dr_shift   = in_sh_dr;
  assign dr_update  = in_upd_dr;
  assign dr_si      = ser_in;
endmodule

// File: rtl/jtag_tap_checker.sv
module jtag_tap_checker #(
  parameter int IR_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mode,
  input logic [3:0]      code,
  input logic [IR_W-1:0] ir_value,
  input logic [IR_W-1:0] ir_shift,
  input logic            s_bnd,
  input logic            s_byp,
  input logic            s_dbg,
  input logic            oe,
  input logic            so
);
  logic [2:0] ones_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ones_cnt <= 3'd0;
    else if (!mode)     ones_cnt <= 3'd0;
    else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
  end

  AST_FIVE_ONES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (ones_cnt == 3'd5) |-> (code == 4'hF)); // R2
  AST_CAPTURE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 4'hE) |=> (ir_shift == IR_W'(1))); // R4
  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (code != 4'hD && code != 4'hF) |=> $stable(ir_value)); // R5
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({s_bnd, s_byp, s_dbg}) == 1); // R6
  AST_RESET_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 4'hF) |=> (ir_value == '1)); // R7
  AST_OE_IN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> (code == 4'hA || code == 4'h2)); // R9
  AST_QUIET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !so); // R9
endmodule

bind jtag_tap_ctrl jtag_tap_checker #(.IR_W(IR_W)) u_chk (
  .clk(test_clk), .rst_n(por_n), .mode(mode_sel), .code(state_code),
  .ir_value(ir_value), .ir_shift(ir_shift), .s_bnd(sel_boundary),
  .s_byp(sel_bypass), .s_dbg(sel_debug), .oe(ser_oe), .so(ser_out)
);

// File: tb/jtag_tap_ctrl_bench.sv
`timescale 1ns/1ps
module jtag_tap_ctrl_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic por_n, tms, tdi, bnd_so, dbg_so;
  logic ser_out, ser_oe, sel_boundary, sel_bypass, sel_debug, bnd_drive;
  logic dr_capture, dr_shift, dr_update, dr_si;
  logic [3:0] state_code, ir_value;

  jtag_tap_ctrl u_jtag_tap_ctrl (
    .test_clk(clk), .por_n(por_n), .mode_sel(tms), .ser_in(tdi),
    .ser_out(ser_out), .ser_oe(ser_oe), .state_code(state_code),
    .ir_value(ir_value), .sel_boundary(sel_boundary), .sel_bypass(sel_bypass),
    .sel_debug(sel_debug), .bnd_drive(bnd_drive), .dr_capture(dr_capture),
    .dr_shift(dr_shift), .dr_update(dr_update), .dr_si(dr_si),
    .bnd_so(bnd_so), .dbg_so(dbg_so)
  );

  localparam logic [7:0] CAPT = 8'h3C;
  logic [7:0] chain;
  always_ff @(posedge clk) begin
    if (dr_capture && sel_boundary)    chain <= CAPT;
    else if (dr_shift && sel_boundary) chain <= {dr_si, chain[7:1]};
  end
  assign bnd_so = chain[0];

  int total = 0, bad = 0;
  bit done = 0;
  logic [3:0] ms;

  function automatic logic [3:0] bnext(logic [3:0] s, bit m);
    case (s)
      4'hF: return m ? 4'hF : 4'hC;
      4'hC: return m ? 4'h7 : 4'hC;
      4'h7: return m ? 4'h4 : 4'h6;
      4'h6, 4'h2: return m ? 4'h1 : 4'h2;
      4'h1: return m ? 4'h5 : 4'h3;
      4'h3: return m ? 4'h0 : 4'h3;
      4'h0: return m ? 4'h5 : 4'h2;
      4'h5, 4'hD: return m ? 4'h7 : 4'hC;
      4'h4: return m ? 4'hF : 4'hE;
      4'hE, 4'hA: return m ? 4'h9 : 4'hA;
      4'h9: return m ? 4'hD : 4'hB;
      4'hB: return m ? 4'h8 : 4'hB;
      4'h8: return m ? 4'hD : 4'hA;
      default: return 4'hF;
    endcase
  endfunction

  function automatic logic [2:0] bsel(logic [3:0] op); // {bnd,byp,dbg}
    if (op == 4'h1) return 3'b100;
    if (op == 4'h7) return 3'b001;
    return 3'b010;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(bit m, bit d);
    tms = m; tdi = d;
    @(posedge clk); #1;
    ms = bnext(ms, m);
  endtask

  task automatic to_idle();
    for (int i = 0; i < 5; i++) tick(1, 0);
    tick(0, 0);
  endtask

  task automatic shift_ir(logic [3:0] v, output logic [3:0] got);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) begin
      #2 got[i] = ser_out;
      tick(i == 3, v[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic shift_dr(logic [15:0] d, int n, output logic [15:0] got);
    got = '0;
    tick(1, 0); tick(0, 0);
    chk(dr_capture && !dr_shift, "R10 capture strobe", {dr_capture, dr_shift}, 2);
    tick(0, 0);
    chk(dr_shift && !dr_capture, "R10 shift strobe", {dr_capture, dr_shift}, 1);
    for (int i = 0; i < n; i++) begin
      #2 got[i] = ser_out;
      tick(i == n - 1, d[i]);
    end
    tick(1, 0);
    chk(dr_update, "R10 update strobe", dr_update, 1);
    tick(0, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] g4;
    logic [15:0] g16;
    void'($urandom(32'h5EED));
    dbg_so = 1'b1;
    por_n = 1'b0; tms = 1'b1; tdi = 1'b0; ms = 4'hF;
    #9;
    chk(state_code == 4'hF, "R2 async reset state", state_code, 4'hF);
    chk(ir_value == 4'hF, "R7 reset instruction", ir_value, 4'hF);
    chk(!ser_oe && !ser_out, "R9 reset output quiet", {ser_oe, ser_out}, 0);
    chk(sel_bypass && !sel_boundary && !sel_debug, "R6 reset select", {sel_boundary, sel_bypass, sel_debug}, 2);
    @(negedge clk); por_n = 1'b1;
    tick(0, 0);
    chk(state_code == 4'hC, "R1 enter idle", state_code, 4'hC);

    shift_ir(4'h1, g4);
    chk(g4 == 4'b0001, "R4 capture pattern out", g4, 1);
    chk(ir_value == 4'h1, "R3 instruction loaded", ir_value, 1);
    chk(sel_boundary && bnd_drive, "R11 boundary drive", {sel_boundary, bnd_drive}, 3);

    shift_dr(16'h00A5, 8, g16);
    chk(g16[7:0] == CAPT, "R10 boundary captured out", g16[7:0], CAPT);
    chk(chain == 8'hA5, "R10 boundary chain contents", chain, 8'hA5);

    shift_ir(4'hF, g4);
    chk(sel_bypass && !bnd_drive, "R6 bypass select", {sel_bypass, bnd_drive}, 2);
    shift_dr(16'h0096, 8, g16);
    chk(g16[7:0] == 8'h2C, "R8 bypass one bit late", g16[7:0], 8'h2C);

    shift_ir(4'h7, g4);
    chk(sel_debug, "R6 debug select", sel_debug, 1);
    shift_dr(16'h0000, 4, g16);
    chk(g16[3:0] == 4'hF, "R10 debug path out", g16[3:0], 4'hF);
    shift_ir(4'h5, g4);
    chk(sel_bypass, "R6 unassigned opcode", sel_bypass, 1);

    // R5: pause detour keeps the held instruction
    shift_ir(4'h1, g4);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) tick(i == 3, 1'b0);
    tick(0, 0);
    chk(state_code == 4'hB && ir_value == 4'h1, "R5 pause holds ir", {state_code, ir_value}, 8'hB1);
    tick(1, 0); tick(1, 0);
    chk(state_code == 4'hD && ir_value == 4'h1, "R5 update not yet", {state_code, ir_value}, 8'hD1);
    tick(0, 0);
    chk(ir_value == 4'h0 && bnd_drive == 1'b0, "R5 update applied", {ir_value, bnd_drive}, 0);

    // random walks with periodic five-ones resets
    for (int r = 0; r < 600; r++) begin
      tick(($urandom % 3) == 0, $urandom % 2);
      chk(state_code == ms, "R1 random walk state", state_code, ms);
      #2;
      chk(ser_oe == (ms == 4'hA || ms == 4'h2), "R9 enable in shift", ser_oe, (ms == 4'hA || ms == 4'h2));
      if (r % 60 == 59) begin
        for (int k = 0; k < 5; k++) tick(1, $urandom % 2);
        chk(state_code == 4'hF, "R2 five ones reset", state_code, 4'hF);
        tick(1, 0);
        chk(ir_value == 4'hF, "R7 reset loads bypass", ir_value, 4'hF);
      end
    end

    // random opcodes
    for (int r = 0; r < 40; r++) begin
      logic [3:0] op;
      op = 4'($urandom);
      if (r < 4) op = (r < 2) ? 4'h1 : 4'h7;
      to_idle();
      shift_ir(op, g4);
      chk(g4 == 4'b0001, "R4 random capture", g4, 1);
      chk(ir_value == op, "R3 random opcode", ir_value, op);
      chk({sel_boundary, sel_bypass, sel_debug} == bsel(op), "R6 random decode",
          {sel_boundary, sel_bypass, sel_debug}, bsel(op));
      chk(bnd_drive == (op == 4'h1), "R11 random drive", bnd_drive, op == 4'h1);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule